// File: doc/BRIEF.md
# Transmit Pad Stripper with Start-of-Frame Tagging

This block sits on the transmit path between a client stream and a MAC transmit word interface. Every client frame arrives with six filler bytes in front of the Ethernet header. The block drops those six bytes and realigns what is left across 64-bit word boundaries. As a result, the destination address starts in byte lane 0 of the first output word. The block also recomputes the byte count of the final word. It marks the first output word of every frame with a start-of-frame flag in the sideband, which is the bit position where the input carried an error flag.

Byte lane k of a data word occupies bits [63-8k:56-8k], so lane 0 (bits 63:56) is the first byte on the wire. On both sides the sideband is tuser[3:0]. On the input, tuser[2:0] is the count of valid bytes in the tlast word, with 0 meaning all eight, and tuser[3] is an error flag. On the output, tuser[2:0] uses the same count encoding on the tlast word, and tuser[3] is start-of-frame.

Both sides use valid/ready. A word moves when valid and ready are both high at a rising clock edge. Once the block raises m_tvalid, it holds the word and the valid stable until m_tready takes it. While a frame is flowing through, s_tready follows m_tready in the same cycle, so back-pressure from the MAC reaches the client with no delay. The block always accepts the first word of a frame, because that word produces no output of its own. While the block emits an extra tail word, it holds s_tready low. m_tvalid never depends on m_tready.

Top module: `pad_strip_tx`

## Requirements
- R1: The output byte stream of a frame equals its input byte stream with the first six bytes removed. The seventh input byte appears in lane 0 of the first output word, and bytes keep their order across word boundaries.
- R2: On the output tlast word, tuser[2:0] equals (input tlast-word count − 6) mod 8, with 0 meaning eight bytes. Every output word that is not the tlast word carries tuser[2:0] = 0.
- R3: When the input tlast word holds one to six valid bytes, that word produces no output word of its own. Its bytes complete the previous output word, and tlast is set on that word.
- R4: When the input tlast word holds seven or eight valid bytes (count 7 or 0), the frame produces one extra output tail word after the realigned words. That tail word has tlast set and holds the last one or two bytes.
- R5: Output tuser[3] is 1 on the first output word of each frame and 0 on all other words. This also holds for frames sent back to back with no idle cycle between them.
- R6: A frame of a single input word with six or fewer valid bytes produces no output. A single-word frame with seven or eight bytes produces exactly one output word, with both start-of-frame and tlast set.
- R7: Input tuser[3] has no effect on any output.
- R8: In the output tlast word, the byte lanes beyond the valid byte count are driven to zero.
- R9: While m_tvalid is high and m_tready is low, m_tdata, m_tuser and m_tlast stay stable. No input word is accepted in a cycle where a pending output word is not taken.
- R10: The synchronous reset and the clear input both return the block to waiting for the first word of a frame. Any partly processed frame is discarded, and m_tvalid is low in the cycle after either one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clear | input | 1 | Synchronous clear back to the frame-start state |
| s_tdata | input | 64 | Input data word, lane 0 in bits 63:56 |
| s_tuser | input | 4 | [2:0] byte count of the tlast word (0 = 8), [3] error flag (ignored) |
| s_tlast | input | 1 | Last word of the input frame |
| s_tvalid | input | 1 | Input word valid |
| s_tready | output | 1 | Block accepts the input word |
| m_tdata | output | 64 | Realigned output data word |
| m_tuser | output | 4 | [2:0] byte count of the tlast word (0 = 8), [3] start of frame |
| m_tlast | output | 1 | Last word of the output frame |
| m_tvalid | output | 1 | Output word valid |
| m_tready | input | 1 | Downstream accepts the output word |

## Verification
A wrong carried-over byte register shows up in lanes 0 and 1 of the very next output word. A wrong frame-state bit shows up on the first word of the following frame, either as a missing start-of-frame flag or as stale bytes in front of the new header. A tail word lost or duplicated through a state error breaks the expected word sequence at the next handshake. So every internal fault becomes visible at the ports within one output word, or at the latest on the first word of the next frame. The frames cover every last-word byte count, single-word frames, clears in mid-frame, and random stalls on both sides, so each of these paths is exercised.

// File: rtl/pstrip_pkg.sv
package pstrip_pkg;

  // Frame progress of the stripper
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,  // expecting the first word of a frame
    ST_PASS = 2'd1,  // realigning words, carry bytes held
    ST_TAIL = 2'd2   // emitting the trailing word of carried bytes
  } strip_state_e;

endpackage

// File: rtl/pstrip_ctrl.sv
module pstrip_ctrl
  import pstrip_pkg::*;
#(
  parameter int LANES = 8,
  parameter int PAD   = 6,
  localparam int OCC_W  = $clog2(LANES),
  localparam int HOLD   = LANES - PAD,
  localparam int HOLD_W = HOLD * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [OCC_W-1:0]  in_occ,
  input  logic [HOLD_W-1:0] in_low,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_last,
  output logic              out_sof,
  output logic [OCC_W-1:0]  out_occ,
  output logic              tail_sel,
  output logic [HOLD_W-1:0] carry
);

  localparam logic [OCC_W-1:0] PAD_W = OCC_W'(PAD);

  strip_state_e       state_q;
  logic               sof_q;
  logic [OCC_W-1:0]   occ_q;
  logic [HOLD_W-1:0]  carry_q;
  logic               spill;
  logic [OCC_W-1:0]   shifted_occ;

  // Last word has more bytes than the pad: it needs a word of its own
  assign spill       = (in_occ == '0) || (in_occ > PAD_W);
  // Count wraps modulo the lane count
  assign shifted_occ = in_occ - PAD_W;

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_last  = 1'b0;
    out_occ   = '0;
    case (state_q)
      ST_WAIT: in_ready = 1'b1;
      ST_PASS: begin
        out_valid = in_valid;
        in_ready  = out_ready;
        out_last  = in_last && !spill;
        out_occ   = (in_last && !spill) ? shifted_occ : '0;
      end
      ST_TAIL: begin
        out_valid = 1'b1;
        out_last  = 1'b1;
        out_occ   = occ_q;
      end
      default: in_ready = 1'b0;
    endcase
  end

  assign out_sof  = sof_q;
  assign tail_sel = (state_q == ST_TAIL);
  assign carry    = carry_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      state_q <= ST_WAIT;
      sof_q   <= 1'b0;
      occ_q   <= '0;
      carry_q <= '0;
    end else begin
      case (state_q)
        ST_WAIT: begin
          if (in_valid) begin
            carry_q <= in_low;
            sof_q   <= 1'b1;
            if (!in_last) begin
              state_q <= ST_PASS;
            end else if (spill) begin
              state_q <= ST_TAIL;
              occ_q   <= shifted_occ;
            end
          end
        end
        ST_PASS: begin
          if (in_valid && out_ready) begin
            sof_q   <= 1'b0;
            carry_q <= in_low;
            if (in_last) begin
              occ_q   <= shifted_occ;
              state_q <= spill ? ST_TAIL : ST_WAIT;
            end
          end
        end
        ST_TAIL: begin
          if (out_ready) begin
            sof_q   <= 1'b0;
            state_q <= ST_WAIT;
          end
        end
        default: state_q <= ST_WAIT;
      endcase
    end
  end

endmodule

// File: rtl/pstrip_lanes.sv
module pstrip_lanes #(
  parameter int LANES = 8,
  parameter int HOLD  = 2,
  localparam int DATA_W = LANES * 8,
  localparam int HOLD_W = HOLD * 8,
  localparam int CNT_W  = $clog2(LANES) + 1
) (
  input  logic [HOLD_W-1:0] carry,
  input  logic [DATA_W-1:0] in_data,
  input  logic              tail_sel,
  input  logic              trim,
  input  logic [CNT_W-1:0]  keep_cnt,
  output logic [DATA_W-1:0] out_data
);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [7:0] src;
    logic       keep;
    if (j < HOLD) begin : g_from_carry
      assign src = carry[HOLD_W-1-8*j -: 8];
    end else begin : g_from_input
      assign src = tail_sel ? 8'h00 : in_data[DATA_W-1-8*(j-HOLD) -: 8];
    end
    assign keep = !trim || (CNT_W'(j) < keep_cnt);
    assign out_data[DATA_W-1-8*j -: 8] = keep ? src : 8'h00;
  end

endmodule

// File: rtl/pad_strip_tx.sv
module pad_strip_tx #(
  parameter int DATA_W    = 64,
  parameter int PAD_BYTES = 6,
  localparam int LANES  = DATA_W / 8,
  localparam int OCC_W  = $clog2(LANES),
  localparam int USER_W = OCC_W + 1,
  localparam int HOLD   = LANES - PAD_BYTES,
  localparam int CNT_W  = OCC_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic [USER_W-1:0] s_tuser,
  input  logic              s_tlast,
  input  logic              s_tvalid,
  output logic              s_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic [USER_W-1:0] m_tuser,
  output logic              m_tlast,
  output logic              m_tvalid,
  input  logic              m_tready
);

  logic [HOLD*8-1:0] carry;
  logic              tail_sel;
  logic              sof;
  logic [OCC_W-1:0]  occ;
  logic [CNT_W-1:0]  keep_cnt;

  pstrip_ctrl #(
    .LANES(LANES),
    .PAD  (PAD_BYTES)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear),
    .in_valid (s_tvalid),
    .in_last  (s_tlast),
    .in_occ   (s_tuser[OCC_W-1:0]),
    .in_low   (s_tdata[HOLD*8-1:0]),
    .in_ready (s_tready),
    .out_valid(m_tvalid),
    .out_ready(m_tready),
    .out_last (m_tlast),
    .out_sof  (sof),
    .out_occ  (occ),
    .tail_sel (tail_sel),
    .carry    (carry)
  );

  assign keep_cnt = (occ == '0) ? CNT_W'(LANES) : {1'b0, occ};

  pstrip_lanes #(
    .LANES(LANES),
    .HOLD (HOLD)
  ) u_lanes (
    .carry   (carry),
    .in_data (s_tdata),
    .tail_sel(tail_sel),
    .trim    (m_tlast),
    .keep_cnt(keep_cnt),
    .out_data(m_tdata)
  );

  assign m_tuser = {sof, occ};

endmodule

// File: rtl/pad_strip_tx_chk.sv
module pad_strip_tx_chk #(
  parameter int DATA_W = 64,
  parameter int USER_W = 4,
  localparam int OCC_W = USER_W - 1
) (
  input logic              clk,
  input logic              rst,
  input logic              clear,
  input logic [DATA_W-1:0] s_tdata,
  input logic [USER_W-1:0] s_tuser,
  input logic              s_tlast,
  input logic              s_tvalid,
  input logic              s_tready,
  input logic [DATA_W-1:0] m_tdata,
  input logic [USER_W-1:0] m_tuser,
  input logic              m_tlast,
  input logic              m_tvalid,
  input logic              m_tready
);

  // Set between the first and the last output word of a frame
  logic mid_q;
  always_ff @(posedge clk) begin
    if (rst || clear) mid_q <= 1'b0;
    else if (m_tvalid && m_tready) mid_q <= !m_tlast;
  end

  // Upstream keeps an offered word stable until taken (premise of R9)
  upstream_hold_chk: assert property (@(posedge clk) disable iff (rst)
    s_tvalid && !s_tready && !clear |=> s_tvalid && $stable(s_tdata) && $stable(s_tuser) && $stable(s_tlast));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && !m_tready && !clear |=> m_tvalid && $stable(m_tdata) && $stable(m_tuser) && $stable(m_tlast));

  // R9
  no_skip_chk: assert property (@(posedge clk) disable iff (rst)
    s_tvalid && s_tready && m_tvalid |-> m_tready);

  // R5
  sof_first_chk: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && !mid_q |-> m_tuser[USER_W-1]);

  // R5
  sof_once_chk: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && mid_q |-> !m_tuser[USER_W-1]);

  // R2
  occ_mid_chk: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && !m_tlast |-> m_tuser[OCC_W-1:0] == '0);

  // R8
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && m_tlast && m_tuser[OCC_W-1:0] == OCC_W'(1) |-> m_tdata[DATA_W-9:0] == '0);

  // R10
  clear_idle_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> !m_tvalid);

endmodule

bind pad_strip_tx pad_strip_tx_chk #(
  .DATA_W(DATA_W),
  .USER_W(USER_W)
) i_chk (
  .clk     (clk),
  .rst     (rst),
  .clear   (clear),
  .s_tdata (s_tdata),
  .s_tuser (s_tuser),
  .s_tlast (s_tlast),
  .s_tvalid(s_tvalid),
  .s_tready(s_tready),
  .m_tdata (m_tdata),
  .m_tuser (m_tuser),
  .m_tlast (m_tlast),
  .m_tvalid(m_tvalid),
  .m_tready(m_tready)
);

// File: tb/test_pad_strip_tx.sv
module test_pad_strip_tx;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clear = 1'b0;
  logic [63:0] s_tdata = '0;
  logic [3:0]  s_tuser = '0;
  logic        s_tlast = 1'b0;
  logic        s_tvalid = 1'b0;
  logic        s_tready;
  logic [63:0] m_tdata;
  logic [3:0]  m_tuser;
  logic        m_tlast;
  logic        m_tvalid;
  logic        m_tready = 1'b1;

  pad_strip_tx i_pad_strip_tx (
    .clk(clk), .rst(rst), .clear(clear),
    .s_tdata(s_tdata), .s_tuser(s_tuser), .s_tlast(s_tlast),
    .s_tvalid(s_tvalid), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tuser(m_tuser), .m_tlast(m_tlast),
    .m_tvalid(m_tvalid), .m_tready(m_tready)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    logic [63:0] data;
    logic [3:0]  user;
    logic        last;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   gap_pct = 0;
  int   stall_pct = 0;

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  // Downstream ready, changed just after each rising edge
  always begin
    @(posedge clk);
    #1;
    m_tready = ($urandom_range(99) >= stall_pct);
  end

  // Monitor: compare each accepted output word with the scoreboard
  always @(negedge clk) begin
    if (!rst && m_tvalid && m_tready) begin
      if (q.size() == 0) begin
        check(1'b0, $sformatf("R6 unexpected output word actual=%h expected=none", m_tdata));
      end else begin
        exp_t e;
        e = q.pop_front();
        check(m_tdata == e.data,
              $sformatf("R1/R8 [%s] data actual=%h expected=%h", e.tag, m_tdata, e.data));
        check(m_tuser[2:0] == e.user[2:0],
              $sformatf("R2 [%s] count actual=%0d expected=%0d", e.tag, m_tuser[2:0], e.user[2:0]));
        check(m_tuser[3] == e.user[3],
              $sformatf("R5 [%s] sof actual=%0b expected=%0b", e.tag, m_tuser[3], e.user[3]));
        check(m_tlast == e.last,
              $sformatf("R3/R4 [%s] last actual=%0b expected=%0b", e.tag, m_tlast, e.last));
      end
    end
  end

  task automatic send_word(input logic [63:0] d, input logic [3:0] u, input logic l);
    s_tvalid = 1'b1;
    s_tdata  = d;
    s_tuser  = u;
    s_tlast  = l;
    forever begin
      @(negedge clk);
      if (s_tready) break;
    end
    @(posedge clk);
    #1;
    s_tvalid = 1'b0;
    s_tdata  = {$urandom, $urandom};
    if ($urandom_range(99) < gap_pct) begin
      @(posedge clk);
      #1;
    end
  endtask

  // Sends a frame of n bytes; cut > 0 sends only its first cut words (no tlast)
  task automatic send_frame(input int n, input int fid, input bit err, input int cut, input string tag);
    logic [7:0] b[];
    int m, nw, ni, nsend;
    b = new[n];
    for (int i = 0; i < n; i++) b[i] = 8'((fid * 29 + i * 7 + 3) & 255);
    m  = n - 6;
    nw = (m > 0) ? (m + 7) / 8 : 0;
    ni = (n + 7) / 8;
    nsend = (cut > 0) ? cut : ni;
    if (cut > 0) nw = cut - 1;
    for (int w = 0; w < nw; w++) begin
      exp_t e;
      bit   lw;
      lw = (cut == 0) && (w == nw - 1);
      e.data = '0;
      for (int k = 0; k < 8; k++) begin
        int idx = w * 8 + k;
        if (idx < m) e.data[63-8*k -: 8] = b[6 + idx];
      end
      e.user = {(w == 0), lw ? 3'(m % 8) : 3'd0};
      e.last = lw;
      e.tag  = tag;
      q.push_back(e);
    end
    for (int w = 0; w < nsend; w++) begin
      logic [63:0] d;
      bit          lw;
      d  = {$urandom, $urandom};
      lw = (cut == 0) && (w == ni - 1);
      for (int k = 0; k < 8; k++) begin
        int idx = w * 8 + k;
        if (idx < n) d[63-8*k -: 8] = b[idx];
      end
      send_word(d, {err, lw ? 3'(n % 8) : 3'd0}, lw);
    end
  endtask

  task automatic drain();
    int t = 0;
    while (q.size() != 0 && t < 5000) begin
      @(posedge clk);
      t++;
    end
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    string tg;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state, waiting for a first word
    check(m_tvalid == 1'b0, $sformatf("R10 reset m_tvalid actual=%0b expected=0", m_tvalid));
    check(s_tready == 1'b1, $sformatf("R10 reset s_tready actual=%0b expected=1", s_tready));
    @(posedge clk);
    #1;
    rst = 1'b0;

    // Back to back, every tlast-word count, single-word frames (R3 R4 R6)
    gap_pct = 0;
    stall_pct = 0;
    for (int n = 1; n <= 26; n++) begin
      if (n <= 8) tg = "R6";
      else if (n % 8 == 7 || n % 8 == 0) tg = "R4";
      else tg = "R3";
      send_frame(n, n, 1'b0, 0, tg);
    end
    drain();

    // Stalls on both sides (R9)
    gap_pct = 30;
    stall_pct = 40;
    for (int i = 0; i < 12; i++) send_frame(7 + i * 5, 100 + i, 1'b0, 0, "R9");
    send_frame(64, 120, 1'b0, 0, "R9");
    send_frame(65, 121, 1'b0, 0, "R9");
    drain();

    // Error flag set on input has no effect (R7)
    gap_pct = 10;
    stall_pct = 20;
    for (int n = 7; n <= 18; n++) send_frame(n, 200 + n, 1'b1, 0, "R7");
    drain();

    // Clear in mid-frame, then a fresh frame (R10)
    stall_pct = 0;
    gap_pct = 0;
    send_frame(40, 300, 1'b0, 3, "R10");
    drain();
    clear = 1'b1;
    @(posedge clk);
    #1;
    clear = 1'b0;
    @(negedge clk);
    check(m_tvalid == 1'b0, $sformatf("R10 after clear m_tvalid actual=%0b expected=0", m_tvalid));
    @(posedge clk);
    #1;
    send_frame(20, 301, 1'b0, 0, "R10");
    send_frame(15, 302, 1'b0, 0, "R10");
    drain();

    check(q.size() == 0, $sformatf("R1 words left over actual=%0d expected=0", q.size()));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule